// File: doc/BRIEF.md
# Machine-Cycle Timing and Bus Strobe Generator

This block turns the oscillator clock of an 8-bit microcontroller core into machine cycles. A machine cycle is six states of two oscillator clocks each, twelve clocks in all. The block reports which state is active and which half of it is running. It also drives the two external-bus strobes that follow this rhythm: the address latch enable pulse and the active-low program fetch strobe.

Two mode inputs set the strobe pattern of each machine cycle. One says the core is fetching code from external program memory. The other says the cycle is an external data memory access, and it removes both fetch strobes from that cycle. Both inputs are taken once per cycle, at the boundary. The block also qualifies the external reset pin. It synchronises the pin and raises the core reset only after the pin has stayed high across two whole machine cycles.

Top module: `mcyc_timing_gen`

## Requirements
- R1: After reset the state output is one-hot, starts at S1 (bit 0), holds each state for two clocks and advances S1..S6 cyclically, so a machine cycle lasts 12 clocks.
- R2: The phase output is 0 in the first clock of every state and 1 in the second.
- R3: The address latch enable is high for exactly one clock at offset 1 of each six-clock half-cycle, that is at cycle clocks 1 and 7. This holds whatever the mode inputs are.
- R4: In a cycle marked as external code and not as data access, the fetch strobe is low during cycle clocks 3-5 and 9-11, and high at all other clocks.
- R5: In a cycle marked as external data access, the fetch strobe stays high for the whole cycle. Both of its activations are dropped.
- R6: In a cycle not marked as external code, the fetch strobe stays high for the whole cycle.
- R7: The mode inputs are sampled only at the clock edge that ends cycle clock 11, and they govern only the cycle that this edge starts. Values present at any other edge have no effect. The first cycle after reset runs with both modes off.
- R8: The reset pin passes through a two-stage synchroniser. The core reset output goes high at the cycle-boundary edge where the synchronised pin has been seen high at three consecutive boundaries, which is two whole machine cycles, and it stays high while the pin stays high.
- R9: A low synchronised pin clears the qualification count, so the core reset falls on the next edge. A high pulse that spans fewer boundaries than R8 needs never raises it.
- R10: While the synchronous active-low reset is low, the block returns to S1 with phase 0, the latch enable low, the fetch strobe high and the core reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_pin | input | 1 | Asynchronous external reset pin, active high |
| ext_code | input | 1 | Next cycle fetches code from external program memory |
| ext_data | input | 1 | Next cycle is an external data memory access |
| state_oh | output | 6 | One-hot state index, bit 0 = S1 |
| phase_p2 | output | 1 | 0 in the first clock of a state, 1 in the second |
| ale | output | 1 | Address latch enable pulse |
| psen_n | output | 1 | Program fetch strobe, active low |
| core_rst | output | 1 | Qualified reset for the core, active high |

## Verification
The bench uses the default parameters: six states of two clocks, a latch pulse at offset 1, a three-clock fetch window at offset 3, two qualifying cycles and a two-stage synchroniser. With these values every clock position of the cycle is checked against a decode table. A sequence of cycle modes covers all four combinations of code and data access, and between boundaries the mode inputs are driven to their opposite values so that sampling at the wrong edge shows up. Reset-pin pulses are driven both shorter and longer than the qualification window, and one reset is applied while the core reset is high.

// File: rtl/mcyc_pkg.sv
// Shared defaults and types for the machine-cycle timing generator.
package mcyc_pkg;
    localparam int unsigned STATES_DEF         = 6;  // states per machine cycle
    localparam int unsigned CLKS_PER_STATE_DEF = 2;  // oscillator clocks per state
    localparam int unsigned ALE_OFS_DEF        = 1;  // latch pulse offset in a half-cycle
    localparam int unsigned FETCH_OFS_DEF      = 3;  // fetch window start in a half-cycle
    localparam int unsigned FETCH_LEN_DEF      = 3;  // fetch window length in clocks
    localparam int unsigned QUAL_CYCLES_DEF    = 2;  // whole cycles the reset pin must hold
    localparam int unsigned SYNC_STAGES_DEF    = 2;  // reset pin synchroniser depth

    // Access kind latched for one machine cycle.
    typedef struct packed {
        logic ext_code;
        logic ext_data;
    } cyc_mode_t;
endpackage

// File: rtl/mcyc_sequencer.sv
// Machine-cycle sequencer.
// Counts oscillator clocks inside a state and states inside a cycle. It
// publishes the one-hot state, the phase bit, the linear clock position and
// a flag for the last clock of the cycle.
// Assumes CLKS_PER_STATE is even and at least 2, and STATES is at least 2.
module mcyc_sequencer #(
    parameter int unsigned STATES         = 6,
    parameter int unsigned CLKS_PER_STATE = 2,
    parameter int unsigned TICK_W         = $clog2(STATES * CLKS_PER_STATE)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STATES-1:0] state_oh,
    output logic              phase_p2,
    output logic [TICK_W-1:0] tick,
    output logic              last_clk
);
    localparam int unsigned SUB_W = $clog2(CLKS_PER_STATE);
    localparam int unsigned ST_W  = $clog2(STATES);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLKS_PER_STATE - 1);
    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(CLKS_PER_STATE / 2);
    localparam logic [ST_W-1:0]  ST_LAST  = ST_W'(STATES - 1);

    logic [SUB_W-1:0] sub_q;
    logic [ST_W-1:0]  st_q;

    // Advance the clock-in-state counter and, on its wrap, the state counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
            st_q  <= '0;
        end else if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            st_q  <= (st_q == ST_LAST) ? '0 : st_q + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    // One decoder bit per state.
    for (genvar g = 0; g < STATES; g++) begin : g_state
        assign state_oh[g] = (st_q == ST_W'(g));
    end

    // Phase, linear position and end-of-cycle flag.
    always_comb begin
        phase_p2 = (sub_q >= SUB_HALF);
        tick     = TICK_W'(st_q) * TICK_W'(CLKS_PER_STATE) + TICK_W'(sub_q);
        last_clk = (st_q == ST_LAST) && (sub_q == SUB_LAST);
    end
endmodule

// File: rtl/mcyc_strobes.sv
// External bus strobe generator.
// Latches the access mode at each cycle boundary. It decodes the address
// latch enable and the active-low fetch strobe from the clock position
// within each half-cycle.
// Assumes CYCLE_CLKS is even, and that both windows fit inside a half-cycle.
module mcyc_strobes
    import mcyc_pkg::*;
#(
    parameter int unsigned CYCLE_CLKS = 12,
    parameter int unsigned TICK_W     = $clog2(CYCLE_CLKS),
    parameter int unsigned ALE_OFS    = 1,
    parameter int unsigned FETCH_OFS  = 3,
    parameter int unsigned FETCH_LEN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick,
    input  logic              last_clk,
    input  logic              ext_code,
    input  logic              ext_data,
    output logic              ale,
    output logic              psen_n
);
    localparam logic [TICK_W-1:0] HALF    = TICK_W'(CYCLE_CLKS / 2);
    localparam logic [TICK_W-1:0] ALE_POS = TICK_W'(ALE_OFS);
    localparam logic [TICK_W-1:0] F_BEG   = TICK_W'(FETCH_OFS);
    localparam logic [TICK_W-1:0] F_END   = TICK_W'(FETCH_OFS + FETCH_LEN);

    cyc_mode_t        mode_q;
    logic [TICK_W-1:0] pos;
    logic             fetch_win;

    // Capture the access mode for the cycle that the next edge begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (last_clk) begin
            mode_q <= '{ext_code: ext_code, ext_data: ext_data};
        end
    end

    // Fold the position into a half-cycle and decode both strobes.
    always_comb begin
        pos       = (tick >= HALF) ? tick - HALF : tick;
        ale       = (pos == ALE_POS);
        fetch_win = (pos >= F_BEG) && (pos < F_END);
        psen_n    = !(fetch_win && mode_q.ext_code && !mode_q.ext_data);
    end
endmodule

// File: rtl/mcyc_rst_qual.sv
// Reset pin qualifier.
// Synchronises the asynchronous pin. The core reset is raised only after the
// synchronised pin has been high at QUAL_CYCLES+1 consecutive cycle
// boundaries, which guarantees QUAL_CYCLES whole machine cycles.
// Assumes SYNC_STAGES is at least 2.
module mcyc_rst_qual #(
    parameter int unsigned QUAL_CYCLES = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic boundary,
    output logic core_rst
);
    localparam int unsigned CNT_MAX = QUAL_CYCLES + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   pin_s;

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Count boundaries seen with the pin high; any low restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_s) begin
            cnt_q <= '0;
        end else if (boundary && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign core_rst = (cnt_q == CNT_TOP);
endmodule

// File: rtl/mcyc_timing_gen.sv
// Machine-cycle timing and bus strobe generator (top).
// Wires the sequencer, the strobe decoder and the reset qualifier together.
// The oscillator clock drives every register; rst_n is synchronous.
module mcyc_timing_gen
    import mcyc_pkg::*;
#(
    parameter int unsigned STATES         = STATES_DEF,
    parameter int unsigned CLKS_PER_STATE = CLKS_PER_STATE_DEF,
    parameter int unsigned ALE_OFS        = ALE_OFS_DEF,
    parameter int unsigned FETCH_OFS      = FETCH_OFS_DEF,
    parameter int unsigned FETCH_LEN      = FETCH_LEN_DEF,
    parameter int unsigned QUAL_CYCLES    = QUAL_CYCLES_DEF,
    parameter int unsigned SYNC_STAGES    = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin,
    input  logic              ext_code,
    input  logic              ext_data,
    output logic [STATES-1:0] state_oh,
    output logic              phase_p2,
    output logic              ale,
    output logic              psen_n,
    output logic              core_rst
);
    localparam int unsigned CYCLE_CLKS = STATES * CLKS_PER_STATE;
    localparam int unsigned TICK_W     = $clog2(CYCLE_CLKS);

    logic [TICK_W-1:0] tick;
    logic              last_clk;

    mcyc_sequencer #(
        .STATES        (STATES),
        .CLKS_PER_STATE(CLKS_PER_STATE),
        .TICK_W        (TICK_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_oh(state_oh),
        .phase_p2(phase_p2),
        .tick    (tick),
        .last_clk(last_clk)
    );

    mcyc_strobes #(
        .CYCLE_CLKS(CYCLE_CLKS),
        .TICK_W    (TICK_W),
        .ALE_OFS   (ALE_OFS),
        .FETCH_OFS (FETCH_OFS),
        .FETCH_LEN (FETCH_LEN)
    ) u_strb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .last_clk(last_clk),
        .ext_code(ext_code),
        .ext_data(ext_data),
        .ale     (ale),
        .psen_n  (psen_n)
    );

    mcyc_rst_qual #(
        .QUAL_CYCLES(QUAL_CYCLES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (rst_pin),
        .boundary(last_clk),
        .core_rst(core_rst)
    );
endmodule

// File: rtl/mcyc_timing_gen_chk.sv
// Property checker for the timing generator, bound onto every instance.
// Observes the top-level ports only.
module mcyc_timing_gen_chk #(
    parameter int unsigned STATES = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_pin,
    input logic [STATES-1:0] state_oh,
    input logic              phase_p2,
    input logic              ale,
    input logic              psen_n,
    input logic              core_rst
);
    a_r1_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    a_r1_state_moves_after_p2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_p2 |=> (state_oh != $past(state_oh)));

    a_r1_state_holds_after_p1: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_p2 |=> $stable(state_oh));

    a_r2_phase_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_p2 |=> phase_p2);

    a_r2_phase_falls: assert property (@(posedge clk) disable iff (!rst_n)
        phase_p2 |=> !phase_p2);

    a_r3_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r4_no_fetch_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> psen_n);

    a_r8_rst_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> $past(rst_pin, 3));

    a_r10_reset_values: assert property (@(posedge clk)
        !rst_n |=> (state_oh == STATES'(1)) && !phase_p2 && !ale && psen_n && !core_rst);
endmodule

bind mcyc_timing_gen mcyc_timing_gen_chk #(.STATES(STATES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_pin (rst_pin),
    .state_oh(state_oh),
    .phase_p2(phase_p2),
    .ale     (ale),
    .psen_n  (psen_n),
    .core_rst(core_rst)
);

// File: tb/mcyc_timing_gen_bench.sv
`timescale 1ns/1ps
module mcyc_timing_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_pin = 1'b0;
    logic       ext_code = 1'b0;
    logic       ext_data = 1'b0;
    logic [5:0] state_oh;
    logic       phase_p2, ale, psen_n, core_rst;

    int checks = 0;
    int errors = 0;
    int k = 0;
    logic done = 1'b0;

    // bench-side expectation state, derived from the requirements
    logic cur_code = 1'b0, cur_data = 1'b0;
    logic s1 = 1'b0, s2 = 1'b0;
    int   cnt = 0;
    logic saw_rst = 1'b0;

    always #2.5 clk = ~clk;

    mcyc_timing_gen u_mcyc_timing_gen (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin),
        .ext_code(ext_code), .ext_data(ext_data),
        .state_oh(state_oh), .phase_p2(phase_p2),
        .ale(ale), .psen_n(psen_n), .core_rst(core_rst)
    );

    // per cycle clock: {state_oh[5:0], phase, ale, fetch window}
    localparam logic [8:0] DEC_TAB [12] = '{
        9'b000001_0_0_0, 9'b000001_1_1_0, 9'b000010_0_0_0, 9'b000010_1_0_1,
        9'b000100_0_0_1, 9'b000100_1_0_1, 9'b001000_0_0_0, 9'b001000_1_1_0,
        9'b010000_0_0_0, 9'b010000_1_0_1, 9'b100000_0_0_1, 9'b100000_1_0_1
    };

    // cycle modes {code, data}, one per cycle
    localparam logic [1:0] MODES [14] = '{
        2'b10, 2'b11, 2'b10, 2'b00, 2'b01, 2'b10, 2'b11,
        2'b11, 2'b10, 2'b00, 2'b10, 2'b01, 2'b10, 2'b10
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at step %0d: actual=%h expected=%h", tag, k, act, exp);
        end
    endtask

    // Check one clock position, drive inputs, advance expectations by one edge.
    task automatic step(input logic code, input logic data, input logic pin);
        int         t = k % 12;
        logic [8:0] d = DEC_TAB[t];
        logic       exp_ps = !(d[0] && cur_code && !cur_data);
        chk("R1 state", {2'b0, state_oh}, {2'b0, d[8:3]});
        chk("R2 phase", {7'b0, phase_p2}, {7'b0, d[2]});
        chk("R3 ale", {7'b0, ale}, {7'b0, d[1]});
        if (!cur_code)     chk("R6 R7 psen_n", {7'b0, psen_n}, {7'b0, exp_ps});
        else if (cur_data) chk("R5 R7 psen_n", {7'b0, psen_n}, {7'b0, exp_ps});
        else               chk("R4 R7 psen_n", {7'b0, psen_n}, {7'b0, exp_ps});
        if (cnt == 3) chk("R8 core_rst", {7'b0, core_rst}, 8'd1);
        else          chk("R9 core_rst", {7'b0, core_rst}, 8'd0);
        if (core_rst === 1'b1) saw_rst = 1'b1;
        // only the value present at the end of clock 11 may matter
        if (t == 11) begin ext_code = code;  ext_data = data;  end
        else         begin ext_code = ~code; ext_data = ~data; end
        rst_pin = pin;
        if (!s2)                    cnt = 0;
        else if (t == 11 && cnt < 3) cnt++;
        s2 = s1;
        s1 = pin;
        if (t == 11) begin cur_code = code; cur_data = data; end
        @(negedge clk);
        k++;
    endtask

    task automatic do_reset(input logic pin);
        rst_n = 1'b0;
        rst_pin = pin;
        ext_code = 1'b1;
        ext_data = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 state", {2'b0, state_oh}, 8'd1);
        chk("R10 phase", {7'b0, phase_p2}, 8'd0);
        chk("R10 ale", {7'b0, ale}, 8'd0);
        chk("R10 psen_n", {7'b0, psen_n}, 8'd1);
        chk("R10 core_rst", {7'b0, core_rst}, 8'd0);
        rst_n = 1'b1;
        k = 0;
        cur_code = 1'b0; cur_data = 1'b0;
        s1 = 1'b0; s2 = 1'b0; cnt = 0;
    endtask

    task automatic pin_run(input logic pin, input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, pin);
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        // R1..R7: walk the mode table, one entry per machine cycle
        for (int c = 0; c < 14; c++) begin
            for (int i = 0; i < 12; i++) step(MODES[c][1], MODES[c][0], 1'b0);
        end
        // R9: a pulse too short to qualify, then R8: a long hold
        pin_run(1'b0, 5);
        pin_run(1'b1, 20);
        chk("R9 short pulse ignored", {7'b0, saw_rst}, 8'd0);
        pin_run(1'b0, 10);
        pin_run(1'b1, 60);
        chk("R8 long hold accepted", {7'b0, saw_rst}, 8'd1);
        pin_run(1'b0, 8);
        pin_run(1'b1, 40);
        // R10: block reset while the core reset is high
        do_reset(1'b1);
        saw_rst = 1'b0;
        pin_run(1'b1, 50);
        chk("R8 re-qualified after block reset", {7'b0, saw_rst}, 8'd1);
        pin_run(1'b0, 6);
        chk("R9 release drops core_rst", {7'b0, core_rst}, 8'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule